// File: doc/BRIEF.md
# Loopback Serial Port Register File

This block presents the eight-byte register window of a 16550-style serial port, but no line sits behind it. Every byte the host stores in the data register lands in a 16-entry circular queue, and host reads of that same register take the bytes back out in order. The status registers are not driven by pins. The line-status, modem-status and interrupt-identification values are all computed from the queue's fill level, a sticky overrun flag and a few control bits. A one-cycle interrupt pulse tells the host when a read has drained the queue.

The host side is a byte bus with a 3-bit offset, separate write and read strobes, and a registered read-data output. Each cycle carries one access. Bit 7 of the line control register switches offsets 0 and 1 over to the two bytes of a 16-bit divisor. A small access sequencer has three states:
- ST_IDLE: no access was taken in the previous cycle.
- ST_ACCESS: an ordinary access was taken.
- ST_DRAINED: a data read left the queue empty while the transmit-empty enable was set.

The sequencer takes these transitions:
- From any state it enters ST_DRAINED on a draining read (transition "drain").
- Otherwise it enters ST_ACCESS on any other strobe (transition "access").
- Otherwise it enters ST_IDLE (transition "quiet").

The interrupt output is high exactly while the sequencer is in ST_DRAINED.

Top module: `loopback_uart_regs`

## Requirements
- R1: After reset the read data output and the interrupt are 0. Offset 5 reads 0x60, offset 2 reads 0xC1, offset 6 reads 0xB3, and offset 0 reads 0x00.
- R2: Bit 7 of offset 3 selects the divisor. While it is 1, writes and reads at offset 0 go to the divisor's low byte and at offset 1 to its high byte, and neither the queue nor the enable register is touched.
- R3: While bit 7 of offset 3 is 0, a write to offset 0 appends the byte if fewer than 16 are held. A read of offset 0 returns the oldest held byte and removes it, so bytes come back in write order.
- R4: A write to offset 0 when 16 bytes are held is discarded and sets the overrun flag. A read of offset 5 returns the flag in bit 1 and then clears it.
- R5: A read of offset 0 with nothing held returns the byte most recently removed (0x00 if none since reset) and leaves the queue empty.
- R6: A read of offset 0 (bit 7 of offset 3 clear) that leaves the queue empty, while enable bit 1 is set, raises the interrupt for exactly the one cycle after the read is taken.
- R7: Offset 1 (bit 7 of offset 3 clear) stores the written enable byte and reads back only its low four bits. The enable bits are: bit 0 receive level, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R8: Offset 2 reads a byte whose bits 7:6 are always 11. Its low bits are the OR of the codes of all enabled active sources:
  - 0x06 when the overrun flag is set;
  - 0x04 when the fill is at or above the trigger level;
  - 0x02 when the queue is empty;
  - 0x00 when offset 4 bit 1 or bit 0 is set.

  If that OR is zero, the low bits read as 0x01.
- R9: A write to offset 2 sets the trigger level from data bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. After reset the level is 1.
- R10: Offset 5 reads bit 0 = queue not empty, bit 1 = overrun, and bits 6 and 5 = queue empty. All other bits read 0. Writes to offset 5 have no effect.
- R11: Offset 6 always reads bits 7, 5 and 1 as 1. It adds bits 4 and 0 when offset 4 bit 5 is clear, or when that bit is set and fewer than 16 bytes are held. Writes to offset 6 have no effect.
- R12: Offsets 3, 4 and 7 read back exactly the last byte written to them.
- R13: The read data output loads on the clock edge that takes a read strobe and holds until the next taken read. A cycle with both strobes performs only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | One-cycle interrupt pulse after a draining read |

## Verification
Every side effect of an access appears one clock edge after the strobe is taken. This covers the queue append or removal, the overrun set or clear, the register update and the new read data. The interrupt pulse is valid in that same following cycle and is gone one cycle later unless another draining read occurs. The bench raises each strobe for exactly one cycle and samples the read data and the interrupt at the falling edge after the taking edge, which is the first point where both are settled. Status values are therefore always compared against the fill level that results from all earlier accesses.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int unsigned REG_AW = 3;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_DRAINED = 2'd2
    } acc_state_e;

    // bit positions that other logic decodes
    localparam int unsigned LCR_DIVSEL = 7;
    localparam int unsigned EN_RXLVL   = 0;
    localparam int unsigned EN_TXEMPTY = 1;
    localparam int unsigned EN_LINE    = 2;
    localparam int unsigned EN_MODEM   = 3;
    localparam int unsigned MCR_DTR    = 0;
    localparam int unsigned MCR_RTS    = 1;
    localparam int unsigned MCR_AUTOFC = 5;

    // identification codes
    localparam logic [7:0] ID_LINE    = 8'h06;
    localparam logic [7:0] ID_RXLVL   = 8'h04;
    localparam logic [7:0] ID_TXEMPTY = 8'h02;
    localparam logic [7:0] ID_MODEM   = 8'h00;
    localparam logic [7:0] ID_NONE    = 8'h01;
    localparam logic [7:0] ID_TOPBITS = 8'hC0;

    // line status bits
    localparam logic [7:0] LS_READY   = 8'h01;
    localparam logic [7:0] LS_OVERRUN = 8'h02;
    localparam logic [7:0] LS_EMPTY   = 8'h60;

    // modem status bits
    localparam logic [7:0] MS_FIXED   = 8'hA2;
    localparam logic [7:0] MS_CLEAR   = 8'h11;

    function automatic logic [7:0] trig_level(input logic [1:0] code);
        logic [7:0] lvl;
        unique case (code)
            2'b00: lvl = 8'd1;
            2'b01: lvl = 8'd4;
            2'b10: lvl = 8'd8;
            default: lvl = 8'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/lbu_fifo.sv
module lbu_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        pop,
    input  logic [WIDTH-1:0]            din,
    output logic [WIDTH-1:0]            dout,
    output logic [$clog2(DEPTH):0]      count
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    head_q;
    logic [AW-1:0]    tail_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (cnt_q != FULL_CNT);
    assign do_pop  = pop && (cnt_q != '0);
    assign dout    = store[tail_q];
    assign count   = cnt_q;

    genvar gi;
    generate
        for (gi = 0; gi < int'(DEPTH); gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && (head_q == AW'(gi))) begin
                    store[gi] <= din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
            end
            if (do_pop) begin
                tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/lbu_csr.sv
module lbu_csr
    import lbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  lcr,
    output logic [7:0]  mcr,
    output logic [7:0]  ier,
    output logic [7:0]  scr,
    output logic [15:0] divisor,
    output logic [1:0]  trig_code
);
    logic divsel;
    assign divsel = lcr[LCR_DIVSEL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr       <= '0;
            mcr       <= '0;
            ier       <= '0;
            scr       <= '0;
            divisor   <= '0;
            trig_code <= '0;
        end else if (wr_en) begin
            unique case (ofs_e'(addr))
                OFS_DATA: if (divsel) divisor[7:0] <= wdata;
                OFS_IER: begin
                    if (divsel) divisor[15:8] <= wdata;
                    else        ier           <= wdata;
                end
                OFS_IIR: trig_code <= wdata[7:6];
                OFS_LCR: lcr       <= wdata;
                OFS_MCR: mcr       <= wdata;
                OFS_SCR: scr       <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lbu_rdmux.sv
module lbu_rdmux
    import lbu_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic [2:0]               addr,
    input  logic [7:0]               lcr,
    input  logic [7:0]               mcr,
    input  logic [7:0]               ier,
    input  logic [7:0]               scr,
    input  logic [15:0]              divisor,
    input  logic [1:0]               trig_code,
    input  logic [$clog2(DEPTH):0]   count,
    input  logic                     overrun,
    input  logic [7:0]               oldest,
    input  logic [7:0]               last_taken,
    output logic [7:0]               rd_val
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic          divsel;
    logic          is_empty;
    logic [CW-1:0] trig_cnt;
    logic [7:0]    id_val;
    logic [7:0]    ls_val;
    logic [7:0]    ms_val;

    assign divsel   = lcr[LCR_DIVSEL];
    assign is_empty = (count == '0);
    assign trig_cnt = CW'(trig_level(trig_code));

    always_comb begin
        id_val = '0;
        if (ier[EN_LINE] && overrun)       id_val |= ID_LINE;
        if (ier[EN_RXLVL] && (count >= trig_cnt)) id_val |= ID_RXLVL;
        if (ier[EN_TXEMPTY] && is_empty)   id_val |= ID_TXEMPTY;
        if (ier[EN_MODEM] && (mcr[MCR_RTS] || mcr[MCR_DTR])) id_val |= ID_MODEM;
        if (id_val == '0) id_val = ID_NONE;
        id_val |= ID_TOPBITS;
    end

    always_comb begin
        ls_val = '0;
        if (!is_empty) ls_val |= LS_READY;
        if (overrun)   ls_val |= LS_OVERRUN;
        if (is_empty)  ls_val |= LS_EMPTY;
    end

    always_comb begin
        ms_val = MS_FIXED;
        if (!mcr[MCR_AUTOFC] || (count < FULL_CNT)) ms_val |= MS_CLEAR;
    end

    always_comb begin
        unique case (ofs_e'(addr))
            OFS_DATA: rd_val = divsel ? divisor[7:0] : (is_empty ? last_taken : oldest);
            OFS_IER:  rd_val = divsel ? divisor[15:8] : {4'b0000, ier[3:0]};
            OFS_IIR:  rd_val = id_val;
            OFS_LCR:  rd_val = lcr;
            OFS_MCR:  rd_val = mcr;
            OFS_LSR:  rd_val = ls_val;
            OFS_MSR:  rd_val = ms_val;
            OFS_SCR:  rd_val = scr;
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/loopback_uart_regs.sv
module loopback_uart_regs
    import lbu_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [7:0]    lcr_q, mcr_q, ier_q, scr_q;
    logic [15:0]   div_q;
    logic [1:0]    trig_q;
    logic [CW-1:0] fifo_count;
    logic [7:0]    fifo_dout;
    logic [7:0]    last_q;
    logic [7:0]    rd_val;
    logic          ovr_q;
    logic          dlab;

    logic          take_wr, take_rd;
    logic          data_wr, data_rd;
    logic          push, pop, drop, drain;

    acc_state_e    state_q, state_d;

    assign dlab    = lcr_q[LCR_DIVSEL];
    assign take_wr = bus_wr;
    assign take_rd = bus_rd && !bus_wr;
    assign data_wr = take_wr && (ofs_e'(bus_addr) == OFS_DATA) && !dlab;
    assign data_rd = take_rd && (ofs_e'(bus_addr) == OFS_DATA) && !dlab;
    assign push    = data_wr && (fifo_count != FULL_CNT);
    assign drop    = data_wr && (fifo_count == FULL_CNT);
    assign pop     = data_rd && (fifo_count != '0);
    assign drain   = data_rd && ier_q[EN_TXEMPTY] && (fifo_count <= CW'(1));

    lbu_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (bus_wdata),
        .dout  (fifo_dout),
        .count (fifo_count)
    );

    lbu_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (take_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .lcr       (lcr_q),
        .mcr       (mcr_q),
        .ier       (ier_q),
        .scr       (scr_q),
        .divisor   (div_q),
        .trig_code (trig_q)
    );

    lbu_rdmux #(.DEPTH(DEPTH)) u_rdmux (
        .addr       (bus_addr),
        .lcr        (lcr_q),
        .mcr        (mcr_q),
        .ier        (ier_q),
        .scr        (scr_q),
        .divisor    (div_q),
        .trig_code  (trig_q),
        .count      (fifo_count),
        .overrun    (ovr_q),
        .oldest     (fifo_dout),
        .last_taken (last_q),
        .rd_val     (rd_val)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            last_q    <= '0;
            ovr_q     <= 1'b0;
        end else begin
            if (take_rd) bus_rdata <= rd_val;
            if (pop)     last_q    <= fifo_dout;
            if (drop) begin
                ovr_q <= 1'b1;
            end else if (take_rd && (ofs_e'(bus_addr) == OFS_LSR)) begin
                ovr_q <= 1'b0;
            end
        end
    end

    // access sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // access sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ACCESS, ST_DRAINED: begin
                if (drain)                 state_d = ST_DRAINED;
                else if (bus_wr || bus_rd) state_d = ST_ACCESS;
                else                       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // access sequencer: outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            ST_DRAINED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
    parameter int unsigned DEPTH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [7:0]               bus_rdata,
    input logic                     irq_o,
    input logic [$clog2(DEPTH):0]   fifo_count,
    input logic                     ovr_q,
    input logic                     dlab,
    input logic [7:0]               ier_q
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic rd_only;
    logic full_data_wr;
    assign rd_only      = bus_rd && !bus_wr;
    assign full_data_wr = bus_wr && (bus_addr == 3'd0) && !dlab && (fifo_count == FULL_CNT);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL_CNT); // R3
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        full_data_wr |=> ovr_q); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full_data_wr |=> (fifo_count == FULL_CNT)); // R4
    AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 3'd5) |=> !ovr_q); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(rd_only && bus_addr == 3'd0 && !dlab && ier_q[1])); // R6
    AST_ID_TOPBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 3'd2) |=> (bus_rdata[7:6] == 2'b11)); // R8
    AST_LS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 3'd5 && fifo_count == '0) |=> (bus_rdata[6:5] == 2'b11 && !bus_rdata[0])); // R10
    AST_MS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_addr == 3'd6) |=> (bus_rdata[7] && bus_rdata[5] && bus_rdata[1])); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(bus_rdata)); // R13

endmodule

bind loopback_uart_regs lbu_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .fifo_count (fifo_count),
    .ovr_q      (ovr_q),
    .dlab       (dlab),
    .ier_q      (ier_q)
);

// File: tb/loopback_uart_regs_bench.sv
module loopback_uart_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    loopback_uart_regs u_loopback_uart_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic irq);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; irq = irq_o;
    endtask

    function automatic logic [7:0] pat(input int t, input int i);
        return 8'((i * 37) + (t * 11) + 5);
    endfunction

    function automatic logic [7:0] exp_id(input logic [7:0] ier, input int n, input int trig, input bit ovr);
        logic [7:0] v = '0;
        if (ier[2] && ovr) v |= 8'h06;
        if (ier[0] && n >= trig) v |= 8'h04;
        if (ier[1] && n == 0) v |= 8'h02;
        if (v == 0) v = 8'h01;
        return v | 8'hC0;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       q;
        int         lv [4] = '{1, 4, 8, 14};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        rd(3'd5, d, q); chk("R1 line status", d, 8'h60);
        rd(3'd2, d, q); chk("R1 id", d, 8'hC1);
        rd(3'd6, d, q); chk("R1 modem status", d, 8'hB3);
        rd(3'd0, d, q); chk("R1 R5 empty data", d, 8'h00);
        chk("R1 no irq", {7'd0, q}, 8'h00);

        // R12 plain registers, exhaustive on scratch
        wr(3'd3, 8'h1B); rd(3'd3, d, q); chk("R12 lcr", d, 8'h1B);
        wr(3'd4, 8'h03); rd(3'd4, d, q); chk("R12 mcr", d, 8'h03);
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, 8'(v)); rd(3'd7, d, q); chk("R12 scr", d, 8'(v));
        end
        // R10 R11 writes ignored
        wr(3'd5, 8'hFF); rd(3'd5, d, q); chk("R10 lsr write ignored", d, 8'h60);
        wr(3'd6, 8'h00); rd(3'd6, d, q); chk("R11 msr write ignored", d, 8'hB3);

        // R7 enable readback
        for (int v = 0; v < 256; v += 17) begin
            wr(3'd1, 8'(v)); rd(3'd1, d, q); chk("R7 ier low nibble", d, 8'(v) & 8'h0F);
        end
        wr(3'd1, 8'h05);
        // R8 modem code is zero: only modem source enabled
        wr(3'd4, 8'h02);
        wr(3'd1, 8'h08); rd(3'd2, d, q); chk("R8 modem code", d, 8'hC1);
        wr(3'd1, 8'h05);

        // R2 divisor aliasing
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        rd(3'd0, d, q); chk("R2 div low", d, 8'h34);
        rd(3'd1, d, q); chk("R2 div high", d, 8'h12);
        wr(3'd3, 8'h00);
        rd(3'd1, d, q); chk("R2 ier untouched", d, 8'h05);
        rd(3'd5, d, q); chk("R2 queue untouched", d, 8'h60);
        wr(3'd3, 8'h80);
        rd(3'd0, d, q); chk("R2 div low kept", d, 8'h34);
        wr(3'd3, 8'h00);

        // R3 R6 R8 R9 R10 R11 sweep of trigger level and fill
        wr(3'd4, 8'h20);
        wr(3'd1, 8'h07);
        for (int t = 0; t < 4; t++) begin
            wr(3'd2, 8'(t << 6));
            for (int n = 0; n <= 16; n++) begin
                for (int i = 0; i < n; i++) wr(3'd0, pat(t, i));
                rd(3'd2, d, q); chk("R8 R9 id", d, exp_id(8'h07, n, lv[t], 1'b0));
                rd(3'd5, d, q); chk("R10 lsr", d, (n == 0) ? 8'h60 : 8'h01);
                rd(3'd6, d, q); chk("R11 msr autofc", d, (n < 16) ? 8'hB3 : 8'hA2);
                for (int i = 0; i < n; i++) begin
                    rd(3'd0, d, q);
                    chk("R3 order", d, pat(t, i));
                    chk("R6 irq", {7'd0, q}, (i == n - 1) ? 8'h01 : 8'h00);
                end
            end
        end

        // R4 overrun, R11 without auto flow
        wr(3'd4, 8'h02);
        for (int i = 0; i < 16; i++) wr(3'd0, pat(9, i));
        wr(3'd0, 8'hEE);
        rd(3'd2, d, q); chk("R4 R8 id overrun", d, exp_id(8'h07, 16, 14, 1'b1));
        rd(3'd6, d, q); chk("R11 msr full no autofc", d, 8'hB3);
        rd(3'd5, d, q); chk("R4 lsr overrun", d, 8'h03);
        rd(3'd5, d, q); chk("R4 overrun cleared", d, 8'h01);
        for (int i = 0; i < 16; i++) begin
            rd(3'd0, d, q); chk("R4 drop kept order", d, pat(9, i));
        end
        // R5 empty read returns last taken byte; R6 fires on empty read too
        rd(3'd0, d, q); chk("R5 last byte", d, pat(9, 15));
        chk("R6 irq empty read", {7'd0, q}, 8'h01);
        @(negedge clk); chk("R6 pulse ends", {7'd0, irq_o}, 8'h00);
        rd(3'd5, d, q); chk("R5 still empty", d, 8'h60);
        wr(3'd1, 8'h05);
        rd(3'd0, d, q); chk("R6 no irq when disabled", {7'd0, q}, 8'h00);

        // R13 both strobes: write only, rdata holds
        wr(3'd7, 8'h11);
        rd(3'd7, d, q); chk("R13 pre", d, 8'h11);
        @(negedge clk);
        bus_addr = 3'd7; bus_wdata = 8'h5A; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R13 rdata held", bus_rdata, 8'h11);
        @(negedge clk); chk("R13 held idle", bus_rdata, 8'h11);
        rd(3'd7, d, q); chk("R13 write taken", d, 8'h5A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule